// File: doc/BRIEF.md
# Registered-Operand Four-Bit Arithmetic Unit

This block captures two 4-bit operands from one 8-bit input bus into clocked registers and computes an 8-bit result from them under a 3-bit operation code. The low nibble of the bus feeds operand A and the high nibble feeds operand B. Both are written together on a clock edge while the load enable is high. The operation code is not registered. The result follows the stored operands and the current code combinationally, so a new code shows its result in the same cycle.

Both operands are zero-extended to the full result width before every operation. As a result, subtraction wraps modulo 256, the left shift keeps the bit shifted out of A, and the multiply returns the whole product. The stored operands also leave the block on their own ports, so a neighbouring flag unit can compare them.

Top module: `rop_alu`

## Requirements
- R1: While rst_n is low at a rising clock edge, both operand registers become 0 after that edge (synchronous reset).
- R2: When load_en is high at a rising edge and rst_n is high, opa_q takes din[3:0] and opb_q takes din[7:4].
- R3: When load_en is low at a rising edge and rst_n is high, opa_q and opb_q keep their values, whatever din carries.
- R4: Opcode 3'b000 gives result = A + B as an 8-bit sum, so the carry appears in bit 4.
- R5: Opcode 3'b001 gives result = (A - B) mod 256. When B > A this is the two's-complement wrap, for example A=0, B=15 gives 8'hF1.
- R6: Opcode 3'b010 gives result = A shifted right by one, with zeros filled in from the top. Bits 7..3 are always 0.
- R7: Opcode 3'b011 gives result = A shifted left by one, with result bit 0 = 0 and result bit 4 = A[3].
- R8: Opcodes 3'b100, 3'b101 and 3'b110 give the bitwise AND, OR and XOR of A and B in bits 3..0, with bits 7..4 = 0.
- R9: Opcode 3'b111 gives the full 8-bit product A x B, for example 15 x 15 = 8'hE1.
- R10: The result changes in the same cycle as the opcode, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Writes both operand registers from din |
| din | input | 8 | Operand bus: [3:0] to A, [7:4] to B |
| opcode | input | 3 | Operation select, applied combinationally |
| result | output | 8 | Zero-extended result of the selected operation |
| opa_q | output | 4 | Stored operand A |
| opb_q | output | 4 | Stored operand B |

## Verification
The hardest situations to reach from the ports are the ones that depend on a particular stored operand pair, not on the code alone. These are a subtraction that wraps with B greater than A, a left shift that carries A[3] out into bit 4, and the largest product. Each needs the right nibbles loaded first and then held while the code is swept. The stimulus loads random operand pairs, sometimes with load_en low so that the registers must hold against a changing din. After every load it walks all eight codes. Directed loads of 0/15, 15/15 and 8/x pin down the wrap, carry and shift-out corners.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int DEF_OPW = 4;
    localparam int OPC_W   = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_SHR = 3'b010,
        OP_SHL = 3'b011,
        OP_AND = 3'b100,
        OP_OR  = 3'b101,
        OP_XOR = 3'b110,
        OP_MUL = 3'b111
    } alu_op_e;

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/rop_opnd_regs.sv
module rop_opnd_regs #(
    parameter int OPW = alu4_pkg::DEF_OPW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [2*OPW-1:0] din,
    output logic [OPW-1:0]   a_q,
    output logic [OPW-1:0]   b_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load_en) begin
            a_q <= din[OPW-1:0];
            b_q <= din[2*OPW-1:OPW];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (a_q == '0) && (b_q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (a_q == $past(din[OPW-1:0])) && (b_q == $past(din[2*OPW-1:OPW])));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(a_q) && $stable(b_q));

endmodule

// File: rtl/rop_mul_array.sv
module rop_mul_array #(
    parameter int OPW  = alu4_pkg::DEF_OPW,
    localparam int RESW = 2*OPW
) (
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    output logic [RESW-1:0] prod
);

    logic [RESW-1:0] pp [OPW];
    logic [RESW-1:0] a_ext;

    assign a_ext = {{(RESW-OPW){1'b0}}, a};

    for (genvar i = 0; i < OPW; i++) begin : g_pp
        assign pp[i] = b[i] ? (a_ext << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int k = 0; k < OPW; k++) begin
            prod = prod + pp[k];
        end
    end

endmodule

// File: rtl/rop_alu_core.sv
module rop_alu_core
    import alu4_pkg::*;
#(
    parameter int OPW  = DEF_OPW,
    localparam int RESW = 2*OPW
) (
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    input  logic [OPC_W-1:0] opcode,
    output logic [RESW-1:0]  result
);

    logic [RESW-1:0] wa, wb, prod;
    alu_op_e         op;

    assign wa = {{(RESW-OPW){1'b0}}, a};
    assign wb = {{(RESW-OPW){1'b0}}, b};
    assign op = alu_op_e'(opcode);

    rop_mul_array #(.OPW(OPW)) u_mul (
        .a    (a),
        .b    (b),
        .prod (prod)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  result = wa + wb;
            OP_SUB:  result = wa - wb;
            OP_SHR:  result = wa >> 1;
            OP_SHL:  result = wa << 1;
            OP_AND:  result = wa & wb;
            OP_OR:   result = wa | wb;
            OP_XOR:  result = wa ^ wb;
            OP_MUL:  result = prod;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rop_alu.sv
module rop_alu
    import alu4_pkg::*;
#(
    parameter int OPW  = DEF_OPW,
    localparam int RESW = 2*OPW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [RESW-1:0]  din,
    input  logic [OPC_W-1:0] opcode,
    output logic [RESW-1:0]  result,
    output logic [OPW-1:0]   opa_q,
    output logic [OPW-1:0]   opb_q
);

    rop_opnd_regs #(.OPW(OPW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .din     (din),
        .a_q     (opa_q),
        .b_q     (opb_q)
    );

    rop_alu_core #(.OPW(OPW)) u_core (
        .a      (opa_q),
        .b      (opb_q),
        .opcode (opcode),
        .result (result)
    );

    p_add_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ADD) |-> (result[RESW-1:OPW+1] == '0));

    p_sub_nowrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SUB && opa_q >= opb_q) |-> (result[RESW-1:OPW] == '0));

    p_sub_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SUB && opa_q < opb_q) |-> result[RESW-1]);

    p_shr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SHR) |-> (result[RESW-1:OPW-1] == '0));

    p_shl_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SHL) |-> (!result[0] && (result[OPW] == opa_q[OPW-1])));

    p_logic_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic_op(alu_op_e'(opcode)) |-> (result[RESW-1:OPW] == '0));

    p_mul_unit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_MUL && opb_q == OPW'(1)) |-> (result == {{(RESW-OPW){1'b0}}, opa_q}));

endmodule

// File: tb/sim_rop_alu.sv
module sim_rop_alu;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_en;
    logic [7:0] din;
    logic [2:0] opcode;
    logic [7:0] result;
    logic [3:0] opa_q, opb_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [3:0] ma, mb;

    always #(CLK_PERIOD/2) clk = ~clk;

    rop_alu u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .din     (din),
        .opcode  (opcode),
        .result  (result),
        .opa_q   (opa_q),
        .opb_q   (opb_q)
    );

    function automatic logic [7:0] exp_res(logic [2:0] op, logic [3:0] a, logic [3:0] b);
        logic [7:0] xa = {4'b0, a};
        logic [7:0] xb = {4'b0, b};
        case (op)
            3'b000: return xa + xb;
            3'b001: return xa - xb;
            3'b010: return {5'b0, a[3:1]};
            3'b011: return {3'b0, a, 1'b0};
            3'b100: return {4'b0, a & b};
            3'b101: return {4'b0, a | b};
            3'b110: return {4'b0, a ^ b};
            default: return xa * xb;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'b000: return "R4";
            3'b001: return "R5";
            3'b010: return "R6";
            3'b011: return "R7";
            3'b111: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_regs(string req);
        chk(req, {4'b0, opa_q}, {4'b0, ma});
        chk(req, {4'b0, opb_q}, {4'b0, mb});
    endtask

    // R10: each opcode result is sampled 1 time unit after the code changes, no edge between
    task automatic sweep_ops();
        for (int op = 0; op < 8; op++) begin
            opcode = 3'(op);
            #1;
            chk({req_of(3'(op)), "/R10"}, result, exp_res(3'(op), ma, mb));
        end
    endtask

    task automatic cycle(logic en, logic [7:0] d);
        @(negedge clk);
        load_en = en;
        din     = d;
        @(posedge clk);
        if (en) begin
            ma = d[3:0];
            mb = d[7:4];
        end
        #1;
        load_en = 1'b0;
        din     = ~d;
        chk_regs(en ? "R2" : "R3");
        sweep_ops();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n   = 1'b0;
        load_en = 1'b1;
        din     = 8'hA5;
        opcode  = 3'b000;
        ma = 4'h0;
        mb = 4'h0;
        repeat (2) @(posedge clk);
        #1;
        chk_regs("R1");
        chk("R1", result, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        cycle(1'b1, 8'hF0);   // A=0, B=15: sub wraps to F1 (R5)
        cycle(1'b1, 8'hFF);   // 15*15 = E1 (R9), 15+15 = 1E (R4)
        cycle(1'b1, 8'h38);   // A=8: shl gives 10 (R7), shr gives 04 (R6)
        cycle(1'b0, 8'h12);   // hold (R3)
        cycle(1'b1, 8'h00);

        // synchronous reset in the middle of operation (R1)
        cycle(1'b1, 8'h9C);
        @(negedge clk);
        rst_n   = 1'b0;
        load_en = 1'b1;
        din     = 8'h77;
        @(posedge clk);
        ma = 4'h0;
        mb = 4'h0;
        #1;
        chk_regs("R1");
        @(negedge clk);
        rst_n   = 1'b1;
        load_en = 1'b0;

        // random mix of loads and holds
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            cycle(r[9:8] != 2'b00, r[7:0]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule